// File: doc/BRIEF.md
# SD Card Bus Clock Divider

This block derives the clock that drives an SD card bus from the controller's base clock. Software programs one 16-bit control word. The word holds a 10-bit division value, an enable for the internal clock, an enable for the card clock and a stored mode bit. The block first waits for the internal clock to settle and reports this through a stable flag in the same word. Once the internal clock is stable and the card clock is enabled, the block produces the divided clock. With a division value N of at least 1, the output period is 2N base cycles. With N = 0, the base clock passes through unchanged.

The output is glitch free. A new division value or a new enable state is taken up only at the end of a low phase of the output, so every pulse keeps its full width. When an enable is removed, the current period runs to its end and the output then rests low. The control word is written and read over a plain register port. This port has no valid/ready handshake and no back-pressure: a write strobe is accepted in every cycle it is high, and the read value is always present.

Top module: `sd_clkdiv_top`

## Requirements
- R1: After reset the control word reads 0x0000 and card_clk is low.
- R2: Layout of the control word:
  - Bits 15:8 hold the low 8 bits of N and bits 7:6 hold the upper 2 bits of N.
  - Bit 5 is the programmable-mode bit, bit 2 is the card clock enable and bit 0 is the internal clock enable. All three are stored and read back as written.
  - Bits 4:3 always read 0.
  - Bit 1 reads the stable flag, and writes to bit 1 are ignored.
- R3: The stable flag reads 1 exactly SETTLE_CYC base cycles after the clock edge that stores internal enable = 1. It reads 0 in the cycle right after a write that clears internal enable.
- R4: card_clk has no rising edge unless internal enable, stable and card clock enable are all 1.
- R5: For N >= 1, card_clk has a period of 2N base cycles, with N cycles high and N cycles low. For N = 0, card_clk equals the base clock.
- R6: A change of N or of an enable takes effect only at the end of a low phase. While the change happens, no high or low pulse is shorter than the shorter half period of the old and new settings.
- R7: The programmable-mode bit has no effect on card_clk.
- R8: After card clock enable or internal enable is cleared, card_clk finishes its current period and then stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Stores wr_data into the control word at the clock edge |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Current control word, including the stable flag |
| card_clk | output | 1 | Gated and divided card bus clock |

## Verification
The division value is stepped through 0, 1, 3, 1023 and 256, with the output running between steps. In each setting, periods and pulse widths are timed on the output:
- N = 0 shows whether the bypass path is taken.
- N = 1 and N = 3 expose off-by-one errors in the phase counter.
- N = 1023 reaches the largest ratio, 2046.
- N = 256, which sets only the upper field, tells whether the two divisor fields are joined in the right order.

Each step is also timed across the change itself, to catch shortened pulses. Clearing each enable separately, and setting the stable bit or the mode bit by a write, show whether start and stop are tied to the handshake alone.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
  localparam int CTL_W  = 16;
  localparam int DIVF_W = 10;

  typedef struct packed {
    logic [7:0] div_lo;
    logic [1:0] div_hi;
    logic       pgm_mode;
    logic [1:0] rsvd;
    logic       card_on;
    logic       settled;
    logic       core_on;
  } ctl_word_t;
endpackage

// File: rtl/sdclk_regs.sv
`timescale 1ns/1ps
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter bit WIDE_DIV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  input  logic              settled,
  output logic [CTL_W-1:0]  rd_data,
  output logic              core_on,
  output logic              card_on,
  output logic [DIVF_W-1:0] div_val
);
  ctl_word_t wr_w;
  ctl_word_t rd_w;
  logic [7:0] lo_q;
  logic [1:0] hi_f;
  logic       pgm_q, card_q, core_q;
  logic       unused_wr;

  assign wr_w      = ctl_word_t'(wr_data);
  assign unused_wr = ^{wr_w.rsvd, wr_w.settled, pgm_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      pgm_q  <= 1'b0;
      card_q <= 1'b0;
      core_q <= 1'b0;
    end else if (wr_en) begin
      lo_q   <= wr_w.div_lo;
      pgm_q  <= wr_w.pgm_mode;
      card_q <= wr_w.card_on;
      core_q <= wr_w.core_on;
    end
  end

  generate
    if (WIDE_DIV) begin : g_wide
      logic [1:0] hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_q <= '0;
        else if (wr_en) hi_q <= wr_w.div_hi;
      end
      assign hi_f = hi_q;
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = ^wr_w.div_hi;
      assign hi_f      = 2'b00;
    end
  endgenerate

  always_comb begin
    rd_w          = '0;
    rd_w.div_lo   = lo_q;
    rd_w.div_hi   = hi_f;
    rd_w.pgm_mode = pgm_q;
    rd_w.card_on  = card_q;
    rd_w.settled  = settled;
    rd_w.core_on  = core_q;
  end

  assign rd_data = rd_w;
  assign core_on = core_q;
  assign card_on = card_q;
  assign div_val = {hi_f, lo_q};
endmodule

// File: rtl/sdclk_settle.sv
`timescale 1ns/1ps
module sdclk_settle #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic core_on,
  output logic settled
);
  localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!core_on) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  // Drops in the same cycle the enable goes away.
  assign settled = core_on & done_q;
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_req,
  input  logic [DIV_W-1:0] div_req,
  output logic             card_clk,
  output logic             div_level,
  output logic [DIV_W-1:0] act_div
);
  logic [DIV_W-1:0] act_div_q, ph_q;
  logic             act_run_q, lvl_q, gate_n_q;
  logic             act_byp, tick, from_byp, load;

  assign act_byp  = (act_div_q == '0);
  assign tick     = (ph_q == act_div_q - DIV_W'(1));
  assign from_byp = act_run_q & act_byp;
  // New settings are accepted only while the divided level is low and
  // its low phase is over (or nothing divided is running).
  assign load     = !lvl_q && (!act_run_q || act_byp || tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div_q <= '0;
      act_run_q <= 1'b0;
      ph_q      <= '0;
      lvl_q     <= 1'b0;
    end else if (load) begin
      act_run_q <= run_req;
      act_div_q <= div_req;
      ph_q      <= '0;
      lvl_q     <= run_req && (div_req != '0) && !from_byp;
    end else if (tick) begin
      ph_q  <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      ph_q <= ph_q + DIV_W'(1);
    end
  end

  // Bypass gate and path select change only while the base clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_n_q <= 1'b0;
    else        gate_n_q <= act_run_q & act_byp;
  end

  assign card_clk  = gate_n_q ? clk : lvl_q;
  assign div_level = lvl_q;
  assign act_div   = act_div_q;
endmodule

// File: rtl/sd_clkdiv_top.sv
`timescale 1ns/1ps
module sd_clkdiv_top
  import sdclk_pkg::*;
#(
  parameter int SETTLE_CYC = 16,
  parameter bit WIDE_DIV   = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        card_clk
);
  logic              core_on, card_on, settled, div_level;
  logic [DIVF_W-1:0] div_val, act_div;

  sdclk_regs #(.WIDE_DIV(WIDE_DIV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .settled(settled), .rd_data(rd_data), .core_on(core_on),
    .card_on(card_on), .div_val(div_val)
  );

  sdclk_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .core_on(core_on), .settled(settled)
  );

  sdclk_gen #(.DIV_W(DIVF_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .run_req(core_on & settled & card_on),
    .div_req(div_val), .card_clk(card_clk), .div_level(div_level),
    .act_div(act_div)
  );
endmodule

// File: rtl/sdclk_chk.sv
`timescale 1ns/1ps
module sdclk_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] rd_data,
  input logic        div_level,
  input logic [9:0]  act_div
);
  logic [10:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (div_level) hi_len <= hi_len + 11'd1;
    else                hi_len <= '0;
  end

  // R2
  divisor_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[15:8] == $past(wr_data[15:8]));

  // R3
  stable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> !rd_data[1]);

  // R3
  stable_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[1]) |-> (rd_data[0] && $past(rd_data[0])));

  // R4
  start_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_level) |-> $past(rd_data[1] && rd_data[2]));

  // R5
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(div_level) |-> hi_len == {1'b0, act_div});
endmodule

bind sd_clkdiv_top sdclk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .div_level(div_level), .act_div(act_div)
);

// File: tb/tb_sd_clkdiv_top.sv
`timescale 1ns/1ps
module tb_sd_clkdiv_top;
  localparam int SETTLE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        card_clk;

  always #5 clk = ~clk;

  sd_clkdiv_top #(.SETTLE_CYC(SETTLE), .WIDE_DIV(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .card_clk(card_clk)
  );

  int     total = 0;
  int     bad = 0;
  longint t_rise = -1, t_fall = -1, last_period = 0;
  longint min_hi = 64'd1000000000, min_lo = 64'd1000000000;
  int     rises = 0;

  always @(posedge card_clk) begin
    longint now;
    now = $time;
    if (t_rise >= 0) last_period = now - t_rise;
    if (t_fall >= 0 && (now - t_fall) < min_lo) min_lo = now - t_fall;
    t_rise = now;
    rises++;
  end

  always @(negedge card_clk) begin
    longint now;
    now = $time;
    if (t_rise >= 0 && (now - t_rise) < min_hi) min_hi = now - t_rise;
    t_fall = now;
  end

  task automatic clear_stats();
    t_rise = -1; t_fall = -1; last_period = 0; rises = 0;
    min_hi = 64'd1000000000; min_lo = 64'd1000000000;
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] make(int n, bit pgm, bit cen, bit ien);
    logic [9:0] v;
    v = 10'(n);
    return {v[7:0], v[9:8], pgm, 2'b00, cen, 1'b0, ien};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int half_ns(int n);
    return (n == 0) ? 5 : 10 * n;
  endfunction

  // Switch from divisor oldn to newn while running, then check the steady state.
  task automatic change_div(int oldn, int newn);
    int wmin, span;
    wmin = (half_ns(oldn) < half_ns(newn)) ? half_ns(oldn) : half_ns(newn);
    span = (newn == 0) ? 1 : 2 * newn;
    clear_stats();
    wr(make(newn, 0, 1, 1));
    chk("R2", "readback", rd_data, make(newn, 0, 1, 1) | 16'h0002);
    step(2 * oldn + 3 * span + 6);
    chk("R6", $sformatf("min high %0d->%0d ok", oldn, newn), min_hi >= wmin, 1);
    chk("R6", $sformatf("min low %0d->%0d ok", oldn, newn), min_lo >= wmin, 1);
    chk("R5", $sformatf("period N=%0d", newn), last_period, 2 * half_ns(newn));
    clear_stats();
    step(3 * span + 2);
    chk("R5", $sformatf("high N=%0d", newn), min_hi, half_ns(newn));
    chk("R5", $sformatf("low N=%0d", newn), min_lo, half_ns(newn));
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    chk("R1", "reset word", rd_data, 16'h0000);
    chk("R1", "reset clk", card_clk, 0);

    // R2: stable bit not writable, reserved bits read 0
    wr(16'hA5DE);
    chk("R2", "layout", rd_data, 16'hA5DE & 16'hFFE5);

    // R3 / R4: settle before any edge, bypass mode N=0
    wr(16'h0000);
    clear_stats();
    wr(make(0, 0, 1, 1));
    step(SETTLE - 1);
    chk("R3", "stable early", rd_data[1], 0);
    step(1);
    chk("R3", "stable on time", rd_data[1], 1);
    chk("R4", "no edge before start", rises, 0);
    step(12);
    clear_stats();
    step(10);
    chk("R5", "bypass period", last_period, 10);
    chk("R5", "bypass high", min_hi, 5);

    change_div(0, 1);
    change_div(1, 3);
    change_div(3, 1023);
    change_div(1023, 256);
    change_div(256, 0);
    change_div(0, 3);

    // R7: mode bit stored, output unchanged
    clear_stats();
    wr(make(3, 1, 1, 1));
    chk("R7", "mode readback", rd_data, make(3, 1, 1, 1) | 16'h0002);
    step(20);
    chk("R7", "period with mode", last_period, 60);
    chk("R7", "no short pulse", (min_hi >= 30) && (min_lo >= 30), 1);

    // R8: card enable cleared
    clear_stats();
    wr(make(3, 0, 0, 1));
    step(8);
    chk("R8", "low after card off", card_clk, 0);
    chk("R8", "full pulses on stop", min_hi >= 30, 1);
    clear_stats();
    step(20);
    chk("R8", "quiet after card off", rises, 0);
    chk("R3", "stable kept", rd_data[1], 1);

    // R8 / R3: internal enable cleared
    wr(make(1, 0, 1, 1));
    step(10);
    wr(make(1, 0, 1, 0));
    chk("R3", "stable drops", rd_data[1], 0);
    step(6);
    chk("R8", "low after core off", card_clk, 0);
    clear_stats();
    step(10);
    chk("R8", "quiet after core off", rises, 0);

    // R4: restart waits for settle again
    clear_stats();
    wr(make(1, 0, 1, 1));
    step(SETTLE);
    chk("R4", "no edge during settle", rises, 0);
    step(10);
    chk("R4", "runs after settle", rises > 0, 1);

    summary();
    $finish;
  end
endmodule